// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the source and destination addresses of one DMA channel and advances them after every 16-bit bus access. Each side has its own address mode and its own choice between two index sets. An index set holds an element stride and a frame stride. The channel controller pulses a strobe for each finished access. It also says whether that access belongs to the last element of a frame and whether double-word mode is on. The generator applies the right stride to each side.

At block start both addresses load from the start-address inputs. When auto-initialization is enabled, block completion loads both addresses from shadow registers instead. Software may rewrite the shadow registers at any point during a block. Bus protocol, arbitration and transfer counting live elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both addresses and both shadow registers read 0; an auto-initializing completion with no prior shadow write therefore yields addresses 0.
- R2: `start` loads `src_addr` from `src_start` and `dst_addr` from `dst_start` on the next edge, taking priority over completion and access strobes in the same cycle.
- R3: Mode encoding per side is 00 hold, 01 increment, 10 decrement, 11 indexed. In hold mode an access leaves the address unchanged. Increment and decrement change it by exactly 1 per access, wrapping modulo 2^16.
- R4: In indexed mode an access that is not the last of its frame adds the element stride of the chosen set, and an access with `last_elem`=1 adds the frame stride of that set.
- R5: Each side picks its index set on its own: select 0 uses `elem_idx0`/`frame_idx0` and select 1 uses `elem_idx1`/`frame_idx1`.
- R6: Strides are 16-bit two's complement, so negative strides step downward with wrap-around.
- R7: With `dword`=1 every access updates the addresses. In indexed mode the first half of an element adds 1 and the second half adds the element or frame stride, and `last_elem` counts only on the second half. The half tracker restarts on `start`, on `block_done` and whenever `dword`=0.
- R8: `block_done` with `autoinit`=1 loads both addresses from their shadow registers, overriding an access strobe in the same cycle.
- R9: `block_done` with `autoinit`=0 reloads nothing; an access in the same cycle still updates normally.
- R10: `shadow_wr` stores `src_shadow`/`dst_shadow` at any time, and a write in the same cycle as an auto-initializing completion is the value loaded.
- R11: With no `start`, no auto-initializing completion and no `xfer`, both addresses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Block start: load start addresses |
| src_start | input | 16 | Source start address |
| dst_start | input | 16 | Destination start address |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| src_sel | input | 1 | Source index-set select |
| dst_sel | input | 1 | Destination index-set select |
| elem_idx0 | input | 16 | Element stride, set 0 |
| frame_idx0 | input | 16 | Frame stride, set 0 |
| elem_idx1 | input | 16 | Element stride, set 1 |
| frame_idx1 | input | 16 | Frame stride, set 1 |
| xfer | input | 1 | One 16-bit access completed |
| last_elem | input | 1 | Access belongs to the last element of a frame |
| dword | input | 1 | Double-word mode |
| block_done | input | 1 | Block completion strobe |
| autoinit | input | 1 | Auto-initialization enable |
| shadow_wr | input | 1 | Write strobe for the shadow registers |
| src_shadow | input | 16 | Source shadow value |
| dst_shadow | input | 16 | Destination shadow value |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
The assertions check on every cycle that reset clears the addresses and that start loads them. They also check the ±1 steps of increment and decrement, the hold mode, and that the addresses stay put when no strobe is present. The indexed strides and the set choice, the double-word half sequencing, shadow timing and the auto-initializing reload rely on history across several cycles. These are shown only by the bench's scenarios, which compare against addresses worked out by hand from the requirements.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

    parameter int ADDR_W    = 16;
    parameter int NUM_SIDES = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        AM_HOLD  = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_INDEX = 2'b11
    } amode_e;

    typedef struct packed {
        addr_t elem;
        addr_t frame;
    } idx_set_t;

    typedef struct packed {
        amode_e mode;
        logic   sel;
        addr_t  start;
    } side_cfg_t;

    typedef struct packed {
        logic last;
        logic first_half;
    } step_ctl_t;

    // Amount added to an address after one 16-bit access.
    function automatic addr_t stride(amode_e m, idx_set_t s, step_ctl_t c);
        addr_t d;
        unique case (m)
            AM_INC:   d = addr_t'(1);
            AM_DEC:   d = '1;
            AM_INDEX: begin
                if (c.first_half)  d = addr_t'(1);
                else if (c.last)   d = s.frame;
                else               d = s.elem;
            end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dma_agen_phase.sv
module dma_agen_phase (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic dword,
    input  logic xfer,
    output logic first_half
);
    logic second_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !dword) second_q <= 1'b0;
        else if (xfer)                second_q <= ~second_q;
    end

    assign first_half = dword && !second_q;
endmodule

// File: rtl/dma_agen_step.sv
module dma_agen_step
    import dma_agen_pkg::*;
(
    input  amode_e    mode,
    input  idx_set_t  set0,
    input  idx_set_t  set1,
    input  logic      sel,
    input  step_ctl_t ctl,
    input  addr_t     cur,
    output addr_t     nxt
);
    idx_set_t chosen;

    always_comb begin
        chosen = sel ? set1 : set0;
        nxt    = cur + stride(mode, chosen, ctl);
    end
endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
    import dma_agen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  side_cfg_t cfg,
    input  idx_set_t  set0,
    input  idx_set_t  set1,
    input  step_ctl_t ctl,
    input  logic      start,
    input  logic      reload,
    input  logic      xfer,
    input  logic      shadow_wr,
    input  addr_t     shadow_in,
    output addr_t     addr
);
    addr_t addr_q, shadow_q, reload_val, next_val;

    dma_agen_step u_step (
        .mode (cfg.mode),
        .set0 (set0),
        .set1 (set1),
        .sel  (cfg.sel),
        .ctl  (ctl),
        .cur  (addr_q),
        .nxt  (next_val)
    );

    // A write landing with the completion is the value taken.
    assign reload_val = shadow_wr ? shadow_in : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (shadow_wr) begin
            shadow_q <= shadow_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (start)  addr_q <= cfg.start;
        else if (reload) addr_q <= reload_val;
        else if (xfer)   addr_q <= next_val;
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_start,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic              src_sel,
    input  logic              dst_sel,
    input  logic [ADDR_W-1:0] elem_idx0,
    input  logic [ADDR_W-1:0] frame_idx0,
    input  logic [ADDR_W-1:0] elem_idx1,
    input  logic [ADDR_W-1:0] frame_idx1,
    input  logic              xfer,
    input  logic              last_elem,
    input  logic              dword,
    input  logic              block_done,
    input  logic              autoinit,
    input  logic              shadow_wr,
    input  logic [ADDR_W-1:0] src_shadow,
    input  logic [ADDR_W-1:0] dst_shadow,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int SRC = 0;
    localparam int DST = 1;

    side_cfg_t cfg       [NUM_SIDES];
    addr_t     shadow_in [NUM_SIDES];
    addr_t     addr      [NUM_SIDES];
    idx_set_t  set0, set1;
    step_ctl_t ctl;
    logic      first_half;
    logic      reload;

    always_comb begin
        cfg[SRC]       = '{mode: amode_e'(src_mode), sel: src_sel, start: src_start};
        cfg[DST]       = '{mode: amode_e'(dst_mode), sel: dst_sel, start: dst_start};
        shadow_in[SRC] = src_shadow;
        shadow_in[DST] = dst_shadow;
        set0           = '{elem: elem_idx0, frame: frame_idx0};
        set1           = '{elem: elem_idx1, frame: frame_idx1};
        ctl            = '{last: last_elem, first_half: first_half};
        reload         = block_done && autoinit;
    end

    dma_agen_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .restart    (start || block_done),
        .dword      (dword),
        .xfer       (xfer),
        .first_half (first_half)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dma_agen_side u_side (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg[s]),
            .set0      (set0),
            .set1      (set1),
            .ctl       (ctl),
            .start     (start),
            .reload    (reload),
            .xfer      (xfer),
            .shadow_wr (shadow_wr),
            .shadow_in (shadow_in[s]),
            .addr      (addr[s])
        );
    end

    assign src_addr = addr[SRC];
    assign dst_addr = addr[DST];
endmodule

// File: rtl/dma_addr_gen_checker.sv
module dma_addr_gen_checker
    import dma_agen_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input addr_t       src_start,
    input addr_t       dst_start,
    input logic [1:0]  src_mode,
    input logic [1:0]  dst_mode,
    input logic        xfer,
    input logic        block_done,
    input logic        autoinit,
    input addr_t       src_addr,
    input addr_t       dst_addr
);
    logic quiet;
    assign quiet = !start && !(block_done && autoinit);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (src_addr == '0 && dst_addr == '0));

    a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (src_addr == $past(src_start) && dst_addr == $past(dst_start)));

    a_r3_src_inc: assert property (@(posedge clk) disable iff (rst)
        (quiet && xfer && src_mode == 2'b01) |=> src_addr == addr_t'($past(src_addr) + addr_t'(1)));

    a_r3_dst_dec: assert property (@(posedge clk) disable iff (rst)
        (quiet && xfer && dst_mode == 2'b10) |=> dst_addr == addr_t'($past(dst_addr) - addr_t'(1)));

    a_r3_hold_mode: assert property (@(posedge clk) disable iff (rst)
        (quiet && xfer && src_mode == 2'b00) |=> $stable(src_addr));

    a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (quiet && !xfer) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

bind dma_addr_gen dma_addr_gen_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_start  (src_start),
    .dst_start  (dst_start),
    .src_mode   (src_mode),
    .dst_mode   (dst_mode),
    .xfer       (xfer),
    .block_done (block_done),
    .autoinit   (autoinit),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr)
);

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst, start, src_sel, dst_sel, xfer, last_elem, dword;
    logic        block_done, autoinit, shadow_wr;
    logic [1:0]  src_mode, dst_mode;
    logic [15:0] src_start, dst_start, elem_idx0, frame_idx0, elem_idx1, frame_idx1;
    logic [15:0] src_shadow, dst_shadow, src_addr, dst_addr;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    dma_addr_gen u_dma_addr_gen (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 0; xfer = 0; last_elem = 0; block_done = 0; shadow_wr = 0;
    endtask

    task automatic do_start(input logic [15:0] s, input logic [15:0] d);
        src_start = s; dst_start = d; start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic access(input logic last);
        xfer = 1; last_elem = last;
        @(negedge clk); xfer = 0; last_elem = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); dword = 0; autoinit = 0;
        src_mode = 0; dst_mode = 0; src_sel = 0; dst_sel = 0;
        src_start = 0; dst_start = 0; src_shadow = 0; dst_shadow = 0;
        elem_idx0 = 0; frame_idx0 = 0; elem_idx1 = 0; frame_idx1 = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 src reset", src_addr, 16'h0000);
        check("R1 dst reset", dst_addr, 16'h0000);
        do_start(16'h1234, 16'h5678);
        autoinit = 1; block_done = 1; @(negedge clk); block_done = 0; autoinit = 0;
        check("R1 src shadow reset", src_addr, 16'h0000);
        check("R1 dst shadow reset", dst_addr, 16'h0000);
    endtask

    task automatic t_start_and_modes();
        do_start(16'hFFFE, 16'h0001);
        check("R2 src start", src_addr, 16'hFFFE);
        check("R2 dst start", dst_addr, 16'h0001);
        src_mode = 2'b01; dst_mode = 2'b10;
        access(0); access(0);
        check("R3 inc wrap", src_addr, 16'h0000);
        check("R3 dec wrap", dst_addr, 16'hFFFF);
        repeat (2) @(negedge clk);
        check("R11 idle src", src_addr, 16'h0000);
        check("R11 idle dst", dst_addr, 16'hFFFF);
        src_mode = 2'b00;
        access(1);
        check("R3 hold mode", src_addr, 16'h0000);
        check("R3 dec third", dst_addr, 16'hFFFE);
    endtask

    task automatic t_indexed();
        elem_idx0 = 16'd3; frame_idx0 = 16'h0010;
        elem_idx1 = 16'hFFFE; frame_idx1 = 16'h0100;
        src_mode = 2'b11; dst_mode = 2'b11; src_sel = 0; dst_sel = 1;
        do_start(16'h1000, 16'h2000);
        access(0);
        check("R4 R5 src elem set0", src_addr, 16'h1003);
        check("R6 R5 dst neg elem set1", dst_addr, 16'h1FFE);
        access(0);
        access(1);
        check("R4 src frame stride", src_addr, 16'h1016);
        check("R4 dst frame stride", dst_addr, 16'h20FC);
        do_start(16'h0001, 16'h0000);
        src_sel = 1; dst_sel = 0;
        access(0); access(0);
        check("R6 neg stride wrap", src_addr, 16'hFFFD);
        check("R5 dst swapped set0", dst_addr, 16'h0006);
    endtask

    task automatic t_dword();
        elem_idx0 = 16'd4; frame_idx0 = 16'd8;
        src_mode = 2'b11; src_sel = 0; dst_mode = 2'b01;
        dword = 1;
        do_start(16'h0100, 16'h0200);
        access(0);
        check("R7 first half +1", src_addr, 16'h0101);
        access(0);
        check("R7 second half elem", src_addr, 16'h0105);
        access(1);
        check("R7 last ignored on first half", src_addr, 16'h0106);
        access(1);
        check("R7 second half frame", src_addr, 16'h010E);
        check("R7 dst inc per access", dst_addr, 16'h0204);
        access(0);
        block_done = 1; autoinit = 0; @(negedge clk); block_done = 0;
        access(0);
        check("R7 phase restart on completion", src_addr, 16'h0110);
        dword = 0;
        access(0);
        check("R7 single word elem", src_addr, 16'h0114);
    endtask

    task automatic t_autoinit();
        src_mode = 2'b01; dst_mode = 2'b01;
        do_start(16'h0010, 16'h0020);
        src_shadow = 16'hA000; dst_shadow = 16'hB000; shadow_wr = 1;
        @(negedge clk); shadow_wr = 0;
        access(0);
        src_shadow = 16'hA100; dst_shadow = 16'hB100; shadow_wr = 1;
        @(negedge clk); shadow_wr = 0;
        check("R10 shadow write no addr effect", src_addr, 16'h0011);
        block_done = 1; autoinit = 0; xfer = 1;
        @(negedge clk); block_done = 0; xfer = 0;
        check("R9 no reload without autoinit", src_addr, 16'h0012);
        check("R9 dst no reload", dst_addr, 16'h0022);
        block_done = 1; autoinit = 1; xfer = 1;
        @(negedge clk); block_done = 0; xfer = 0;
        check("R8 src reload latest shadow", src_addr, 16'hA100);
        check("R8 dst reload latest shadow", dst_addr, 16'hB100);
        src_shadow = 16'hC000; dst_shadow = 16'hD000; shadow_wr = 1; block_done = 1;
        @(negedge clk); shadow_wr = 0; block_done = 0;
        check("R10 same-cycle write src", src_addr, 16'hC000);
        check("R10 same-cycle write dst", dst_addr, 16'hD000);
        src_start = 16'h0500; dst_start = 16'h0600;
        start = 1; block_done = 1; xfer = 1;
        @(negedge clk); start = 0; block_done = 0; xfer = 0; autoinit = 0;
        check("R2 start priority src", src_addr, 16'h0500);
        check("R2 start priority dst", dst_addr, 16'h0600);
    endtask

    initial begin
        t_reset();
        t_start_and_modes();
        t_indexed();
        t_dword();
        t_autoinit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule